// File: doc/BRIEF.md
# Branch Resolver with T-State Accounting

This block settles control flow for the one-byte branch opcodes of an 8-bit CPU core: absolute jumps, relative jumps, calls, returns, the decrement-and-loop instruction, restarts and the indirect jump through HL. Each of these has its own condition codes. The sequencer presents one opcode with `valid_i`, together with the flag byte, register B, the program counter (already past the opcode byte), the operand bytes it fetched, HL and the return address it popped. One clock later the block returns a registered result. The result carries the taken decision, the next program counter, the new B, a push request with the address to push, and the T-state cost of the instruction.

The cost depends on the outcome. For a conditional instruction that is not taken, the next program counter already skips the operand bytes that were never used. Memory and stack transfers happen outside the block. So does interrupt handling.

Top module: `branch_resolver`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `taken_o` and `push_o` are 0, and `tstates_o`, `next_pc_o`, `b_o` and `push_addr_o` are 0.
- R2: The result for an instruction presented with `valid_i` high appears on the outputs exactly one clock later, with `valid_o` high. After a clock where `valid_i` is low, `valid_o`, `taken_o` and `push_o` are 0 and `tstates_o` and `push_addr_o` are 0. `next_pc_o` and `b_o` keep their last values.
- R3: The condition code cc is opcode bits 5:3 for conditional jump, call and return. Its values are 0 not-zero, 1 zero, 2 no-carry, 3 carry, 4 parity-odd, 5 parity-even, 6 plus and 7 minus. Relative jumps take cc from bits 4:3 and use only the first four codes. The flags are sign at bit 7, zero at bit 6, parity/overflow at bit 2 and carry at bit 0.
- R4: Absolute jump (0xC3, or 11ccc010 when conditional): when taken, next PC = imm16. When not taken, next PC = PC+2. Both outcomes cost 10 T-states.
- R5: Relative jump (0x18, or 001cc000 when conditional, that is 0x20/0x28/0x30/0x38): when taken, next PC = PC+1 plus the sign-extended imm8, modulo 2^16, and the cost is 12. When not taken, next PC = PC+1 and the cost is 7.
- R6: Decrement-and-loop (0x10): `b_o` = B−1 modulo 256. If that value is nonzero, the jump is taken to the relative target at 13 T-states. Otherwise next PC = PC+1 at 8 T-states.
- R7: Call (0xCD, or 11ccc100 when conditional): when taken, next PC = imm16, `push_o` is 1 with `push_addr_o` = PC+2, and the cost is 17. When not taken, next PC = PC+2, there is no push, and the cost is 10.
- R8: Return (0xC9, or 11ccc000 when conditional): when taken, next PC = the popped address. The cost is 10 for the unconditional form and 11 for a taken conditional one. When not taken, next PC = PC and the cost is 5.
- R9: Restart (11vvv111) is always taken to vector vvv×8. It pushes `push_addr_o` = PC and costs 11.
- R10: Indirect jump (0xE9) is taken to HL at 4 T-states.
- R11: Any other opcode gives `taken_o`=0, next PC = PC, `b_o` = B and `tstates_o`=0, with no push.
- R12: `push_o` is high only in the result cycle of a taken call or a restart, one cycle per instruction. Whenever `push_o` is 0, `push_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| opcode_i | input | 8 | Opcode byte |
| flags_i | input | 8 | Flag byte |
| b_i | input | 8 | Register B |
| pc_i | input | 16 | PC past the opcode byte |
| imm8_i | input | 8 | Relative displacement operand |
| imm16_i | input | 16 | Absolute address operand |
| hl_i | input | 16 | Register HL |
| ret_addr_i | input | 16 | Address popped from the stack |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Next program counter |
| b_o | output | 8 | Updated register B |
| push_o | output | 1 | Stack push request |
| push_addr_o | output | 16 | Return address to push |
| tstates_o | output | 5 | T-states consumed |

## Verification
The hardest corners are where arithmetic wraps. These are a decrement-and-loop with B equal to 1 (falls through) and with B equal to 0 (wraps to 0xFF and loops). Another is a relative jump whose target crosses 0x0000 or 0xFFFF. The full opcode space is swept under four flag bytes, chosen so that every condition code is seen both met and unmet. Directed steps then place B at 0 and 1 and put the PC at both ends of the address space with the largest positive and negative displacements. Idle cycles are interleaved so that held values and the one-cycle push pulse are checked between instructions.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [2:0] {
    CLS_NONE, CLS_JR, CLS_DJNZ, CLS_JP, CLS_JPHL, CLS_CALL, CLS_RET, CLS_RST
  } br_class_e;

  localparam int TS_W = 5;

  localparam logic [TS_W-1:0] TS_JP       = TS_W'(10);
  localparam logic [TS_W-1:0] TS_JR_TK    = TS_W'(12);
  localparam logic [TS_W-1:0] TS_JR_NT    = TS_W'(7);
  localparam logic [TS_W-1:0] TS_DJ_TK    = TS_W'(13);
  localparam logic [TS_W-1:0] TS_DJ_NT    = TS_W'(8);
  localparam logic [TS_W-1:0] TS_CALL_TK  = TS_W'(17);
  localparam logic [TS_W-1:0] TS_CALL_NT  = TS_W'(10);
  localparam logic [TS_W-1:0] TS_RET_U    = TS_W'(10);
  localparam logic [TS_W-1:0] TS_RET_TK   = TS_W'(11);
  localparam logic [TS_W-1:0] TS_RET_NT   = TS_W'(5);
  localparam logic [TS_W-1:0] TS_RST      = TS_W'(11);
  localparam logic [TS_W-1:0] TS_JPHL     = TS_W'(4);

  function automatic logic [TS_W-1:0] br_cost(br_class_e cls, logic cond, logic taken);
    logic [TS_W-1:0] c;
    c = '0;
    unique case (cls)
      CLS_JP:   c = TS_JP;
      CLS_JR:   c = taken ? TS_JR_TK : TS_JR_NT;
      CLS_DJNZ: c = taken ? TS_DJ_TK : TS_DJ_NT;
      CLS_CALL: c = taken ? TS_CALL_TK : TS_CALL_NT;
      CLS_RET:  c = !cond ? TS_RET_U : (taken ? TS_RET_TK : TS_RET_NT);
      CLS_RST:  c = TS_RST;
      CLS_JPHL: c = TS_JPHL;
      default:  c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic [7:0] opcode_i,
  output br_class_e  cls_o,
  output logic       cond_o,
  output logic [2:0] ccc_o,
  output logic [2:0] vec_o
);
  always_comb begin
    cls_o  = CLS_NONE;
    cond_o = 1'b0;
    ccc_o  = 3'd0;
    vec_o  = opcode_i[5:3];
    if (opcode_i == 8'h10) begin
      cls_o = CLS_DJNZ;
    end else if (opcode_i == 8'h18) begin
      cls_o = CLS_JR;
    end else if (opcode_i[7:5] == 3'b001 && opcode_i[2:0] == 3'b000) begin
      cls_o  = CLS_JR;
      cond_o = 1'b1;
      ccc_o  = {1'b0, opcode_i[4:3]};
    end else if (opcode_i == 8'hE9) begin
      cls_o = CLS_JPHL;
    end else if (opcode_i[7:6] == 2'b11) begin
      unique case (opcode_i[2:0])
        3'b000: begin cls_o = CLS_RET;  cond_o = 1'b1; ccc_o = opcode_i[5:3]; end
        3'b010: begin cls_o = CLS_JP;   cond_o = 1'b1; ccc_o = opcode_i[5:3]; end
        3'b100: begin cls_o = CLS_CALL; cond_o = 1'b1; ccc_o = opcode_i[5:3]; end
        3'b111: cls_o = CLS_RST;
        3'b001: if (opcode_i[5:3] == 3'b001) cls_o = CLS_RET;
        3'b011: if (opcode_i[5:3] == 3'b000) cls_o = CLS_JP;
        3'b101: if (opcode_i[5:3] == 3'b001) cls_o = CLS_CALL;
        default: cls_o = CLS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval #(
  parameter int DW     = 8,
  parameter int SIGN_B = 7,
  parameter int ZERO_B = 6,
  parameter int PAR_B  = 2,
  parameter int CARY_B = 0
) (
  input  logic [DW-1:0] flags_i,
  input  logic [2:0]    ccc_i,
  output logic          met_o
);
  // group order follows cc[2:1]: zero, carry, parity, sign
  logic [3:0] grp;
  logic [7:0] hit;

  assign grp = {flags_i[SIGN_B], flags_i[PAR_B], flags_i[CARY_B], flags_i[ZERO_B]};

  for (genvar i = 0; i < 8; i++) begin : g_cc
    if (i % 2 == 1) begin : g_set
      assign hit[i] = grp[i/2];
    end else begin : g_clr
      assign hit[i] = ~grp[i/2];
    end
  end

  assign met_o = hit[ccc_i];
endmodule

// File: rtl/br_target.sv
module br_target
  import br_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  br_class_e     cls_i,
  input  logic          cond_i,
  input  logic          met_i,
  input  logic [2:0]    vec_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] imm8_i,
  input  logic [AW-1:0] imm16_i,
  input  logic [AW-1:0] hl_i,
  input  logic [AW-1:0] ret_addr_i,
  input  logic [DW-1:0] b_i,
  output logic          taken_o,
  output logic [AW-1:0] next_pc_o,
  output logic [DW-1:0] b_o,
  output logic          push_o,
  output logic [AW-1:0] push_addr_o
);
  localparam int EXT = AW - DW;

  logic [AW-1:0] pc_p1, pc_p2, rel_tgt, vec_tgt;
  logic [DW-1:0] b_dec;
  logic          go;

  assign pc_p1   = pc_i + AW'(1);
  assign pc_p2   = pc_i + AW'(2);
  assign rel_tgt = pc_p1 + {{EXT{imm8_i[DW-1]}}, imm8_i};
  assign vec_tgt = AW'({vec_i, 3'b000});
  assign b_dec   = b_i - DW'(1);
  assign go      = !cond_i || met_i;

  always_comb begin
    taken_o     = 1'b0;
    next_pc_o   = pc_i;
    b_o         = b_i;
    push_o      = 1'b0;
    push_addr_o = '0;
    unique case (cls_i)
      CLS_JR: begin
        taken_o   = go;
        next_pc_o = go ? rel_tgt : pc_p1;
      end
      CLS_DJNZ: begin
        b_o       = b_dec;
        taken_o   = (b_dec != '0);
        next_pc_o = (b_dec != '0) ? rel_tgt : pc_p1;
      end
      CLS_JP: begin
        taken_o   = go;
        next_pc_o = go ? imm16_i : pc_p2;
      end
      CLS_CALL: begin
        taken_o     = go;
        next_pc_o   = go ? imm16_i : pc_p2;
        push_o      = go;
        push_addr_o = go ? pc_p2 : '0;
      end
      CLS_RET: begin
        taken_o   = go;
        next_pc_o = go ? ret_addr_i : pc_i;
      end
      CLS_RST: begin
        taken_o     = 1'b1;
        next_pc_o   = vec_tgt;
        push_o      = 1'b1;
        push_addr_o = pc_i;
      end
      CLS_JPHL: begin
        taken_o   = 1'b1;
        next_pc_o = hl_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [DW-1:0]   opcode_i,
  input  logic [DW-1:0]   flags_i,
  input  logic [DW-1:0]   b_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [DW-1:0]   imm8_i,
  input  logic [AW-1:0]   imm16_i,
  input  logic [AW-1:0]   hl_i,
  input  logic [AW-1:0]   ret_addr_i,
  output logic            valid_o,
  output logic            taken_o,
  output logic [AW-1:0]   next_pc_o,
  output logic [DW-1:0]   b_o,
  output logic            push_o,
  output logic [AW-1:0]   push_addr_o,
  output logic [TS_W-1:0] tstates_o
);
  br_class_e     cls;
  logic          cond, met, tk, psh;
  logic [2:0]    ccc, vec;
  logic [AW-1:0] npc, paddr;
  logic [DW-1:0] nb;

  br_decode u_dec (
    .opcode_i (opcode_i[7:0]),
    .cls_o    (cls),
    .cond_o   (cond),
    .ccc_o    (ccc),
    .vec_o    (vec)
  );

  br_cond_eval #(.DW(DW)) u_cc (
    .flags_i (flags_i),
    .ccc_i   (ccc),
    .met_o   (met)
  );

  br_target #(.AW(AW), .DW(DW)) u_tgt (
    .cls_i       (cls),
    .cond_i      (cond),
    .met_i       (met),
    .vec_i       (vec),
    .pc_i        (pc_i),
    .imm8_i      (imm8_i),
    .imm16_i     (imm16_i),
    .hl_i        (hl_i),
    .ret_addr_i  (ret_addr_i),
    .b_i         (b_i),
    .taken_o     (tk),
    .next_pc_o   (npc),
    .b_o         (nb),
    .push_o      (psh),
    .push_addr_o (paddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      taken_o     <= 1'b0;
      next_pc_o   <= '0;
      b_o         <= '0;
      push_o      <= 1'b0;
      push_addr_o <= '0;
      tstates_o   <= '0;
    end else if (valid_i) begin
      valid_o     <= 1'b1;
      taken_o     <= tk;
      next_pc_o   <= npc;
      b_o         <= nb;
      push_o      <= psh;
      push_addr_o <= paddr;
      tstates_o   <= br_cost(cls, cond, tk);
    end else begin
      valid_o     <= 1'b0;
      taken_o     <= 1'b0;
      push_o      <= 1'b0;
      push_addr_o <= '0;
      tstates_o   <= '0;
    end
  end
endmodule

// File: rtl/br_checker.sv
module br_checker
  import br_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [DW-1:0]   opcode_i,
  input logic [DW-1:0]   b_i,
  input logic [AW-1:0]   hl_i,
  input logic            valid_o,
  input logic            taken_o,
  input logic            push_o,
  input logic [AW-1:0]   next_pc_o,
  input logic [DW-1:0]   b_o,
  input logic [TS_W-1:0] tstates_o
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!taken_o && !push_o && tstates_o == '0));

  // R12
  push_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (valid_o && taken_o));

  // R10
  jphl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == DW'(8'hE9)) |=> (next_pc_o == $past(hl_i) && tstates_o == TS_W'(4)));

  // R6
  djnz_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == DW'(8'h10)) |=> (b_o == DW'($past(b_i) - DW'(1))));

  // R9
  rst_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[7:6] == 2'b11 && opcode_i[2:0] == 3'b111)
      |=> (push_o && next_pc_o == AW'({$past(opcode_i[5:3]), 3'b000})));

  // R4
  jp_cost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[7:6] == 2'b11 && opcode_i[2:0] == 3'b010) |=> (tstates_o == TS_W'(10)));
endmodule

bind branch_resolver br_checker #(.AW(AW), .DW(DW)) i_br_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .opcode_i  (opcode_i),
  .b_i       (b_i),
  .hl_i      (hl_i),
  .valid_o   (valid_o),
  .taken_o   (taken_o),
  .push_o    (push_o),
  .next_pc_o (next_pc_o),
  .b_o       (b_o),
  .tstates_o (tstates_o)
);

// File: tb/test_branch_resolver.sv
module test_branch_resolver;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opcode_i = '0, flags_i = '0, b_i = '0, imm8_i = '0;
  logic [15:0] pc_i = '0, imm16_i = '0, hl_i = '0, ret_addr_i = '0;
  logic        valid_o, taken_o, push_o;
  logic [15:0] next_pc_o, push_addr_o;
  logic [7:0]  b_o;
  logic [4:0]  tstates_o;

  int checks = 0;
  int errors = 0;

  // expected outputs for the next compare
  logic        e_valid = 0, e_taken = 0, e_push = 0;
  logic [15:0] e_pc = 0, e_paddr = 0;
  logic [7:0]  e_b = 0;
  int          e_cy = 0;
  string       e_tag = "R1";

  always #10 clk_i = ~clk_i;

  branch_resolver i_branch_resolver (
    .clk_i, .rst_ni, .valid_i, .opcode_i, .flags_i, .b_i, .pc_i, .imm8_i,
    .imm16_i, .hl_i, .ret_addr_i, .valid_o, .taken_o, .next_pc_o, .b_o,
    .push_o, .push_addr_o, .tstates_o
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (op=%02h)", tag, what, act, exp, opcode_i);
    end
  endtask

  function automatic bit cc_met(input int c, input logic [7:0] f);
    case (c)
      0: return !f[6];
      1: return f[6];
      2: return !f[0];
      3: return f[0];
      4: return !f[2];
      5: return f[2];
      6: return !f[7];
      default: return f[7];
    endcase
  endfunction

  function automatic logic [15:0] rel(input logic [15:0] pc, input logic [7:0] d);
    int s;
    s = int'(d);
    if (s > 127) s -= 256;
    return 16'((int'(pc) + 1 + s) & 32'hFFFF);
  endfunction

  task automatic model(input logic [7:0] op, f, bb, d, input logic [15:0] pc, a16, hl, ra);
    int c;
    bit m;
    c = int'(op[5:3]);
    e_valid = 1; e_taken = 0; e_pc = pc; e_b = bb; e_push = 0; e_paddr = 0; e_cy = 0;
    e_tag = "R11";
    if (op == 8'h10) begin
      e_tag = "R6"; e_b = bb - 8'd1;
      if (e_b != 0) begin e_taken = 1; e_pc = rel(pc, d); e_cy = 13; end
      else begin e_pc = pc + 16'd1; e_cy = 8; end
    end else if (op == 8'h18) begin
      e_tag = "R5"; e_taken = 1; e_pc = rel(pc, d); e_cy = 12;
    end else if (op == 8'h20 || op == 8'h28 || op == 8'h30 || op == 8'h38) begin
      e_tag = "R5 R3"; m = cc_met(int'(op[4:3]), f);
      e_taken = m; e_pc = m ? rel(pc, d) : pc + 16'd1; e_cy = m ? 12 : 7;
    end else if (op == 8'hC3) begin
      e_tag = "R4"; e_taken = 1; e_pc = a16; e_cy = 10;
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'b010) begin
      e_tag = "R4 R3"; m = cc_met(c, f);
      e_taken = m; e_pc = m ? a16 : pc + 16'd2; e_cy = 10;
    end else if (op == 8'hCD) begin
      e_tag = "R7"; e_taken = 1; e_pc = a16; e_push = 1; e_paddr = pc + 16'd2; e_cy = 17;
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'b100) begin
      e_tag = "R7 R3"; m = cc_met(c, f);
      e_taken = m; e_pc = m ? a16 : pc + 16'd2; e_push = m;
      e_paddr = m ? pc + 16'd2 : 16'd0; e_cy = m ? 17 : 10;
    end else if (op == 8'hC9) begin
      e_tag = "R8"; e_taken = 1; e_pc = ra; e_cy = 10;
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'b000) begin
      e_tag = "R8 R3"; m = cc_met(c, f);
      e_taken = m; e_pc = m ? ra : pc; e_cy = m ? 11 : 5;
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'b111) begin
      e_tag = "R9"; e_taken = 1; e_pc = 16'(c * 8); e_push = 1; e_paddr = pc; e_cy = 11;
    end else if (op == 8'hE9) begin
      e_tag = "R10"; e_taken = 1; e_pc = hl; e_cy = 4;
    end
  endtask

  task automatic compare_all();
    chk("R2", "valid", int'(valid_o), int'(e_valid));
    chk(e_tag, "taken", int'(taken_o), int'(e_taken));
    chk(e_tag, "next_pc", int'(next_pc_o), int'(e_pc));
    chk(e_tag, "b", int'(b_o), int'(e_b));
    chk({e_tag, " R12"}, "push", int'(push_o), int'(e_push));
    chk({e_tag, " R12"}, "push_addr", int'(push_addr_o), int'(e_paddr));
    chk(e_tag, "tstates", int'(tstates_o), e_cy);
  endtask

  task automatic step(input bit v, input logic [7:0] op, f, bb, d,
                      input logic [15:0] pc, a16, hl, ra);
    @(negedge clk_i);
    compare_all();
    valid_i = v; opcode_i = op; flags_i = f; b_i = bb; imm8_i = d;
    pc_i = pc; imm16_i = a16; hl_i = hl; ret_addr_i = ra;
    if (v) model(op, f, bb, d, pc, a16, hl, ra);
    else begin
      e_valid = 0; e_taken = 0; e_push = 0; e_paddr = 0; e_cy = 0; e_tag = "R2";
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h41; pats[3] = 8'h84;
    repeat (3) @(negedge clk_i);
    compare_all(); // R1 during reset
    rst_ni = 1'b1;
    for (int op = 0; op < 256; op++) begin
      for (int fp = 0; fp < 4; fp++) begin
        step(1'b1, 8'(op), pats[fp], (fp == 0) ? 8'd1 : (fp == 1) ? 8'd0 : 8'(op + fp),
             8'(op ^ (fp * 8'h55)), 16'(16'h1000 + op * 37 + fp),
             16'(16'hA000 + op), 16'(16'h5000 + op * 3), 16'(16'h7000 + op * 5));
      end
      if (op % 5 == 0) step(1'b0, 8'hC7, 8'hFF, 8'h3C, 8'h00, 16'h1234, 16'h0, 16'h0, 16'h0);
    end
    // R5 wrap at both ends of address space
    step(1'b1, 8'h18, 8'h00, 8'h05, 8'h80, 16'h0010, 16'h0, 16'h0, 16'h0);
    step(1'b1, 8'h18, 8'h00, 8'h05, 8'h7F, 16'hFFF0, 16'h0, 16'h0, 16'h0);
    step(1'b1, 8'h38, 8'h01, 8'h05, 8'hFE, 16'hFFFF, 16'h0, 16'h0, 16'h0);
    // R6 boundaries: B=1 falls through, B=0 wraps and loops, B=2 loops backward
    step(1'b1, 8'h10, 8'h00, 8'h01, 8'hF0, 16'h2000, 16'h0, 16'h0, 16'h0);
    step(1'b1, 8'h10, 8'h00, 8'h00, 8'hF0, 16'h0005, 16'h0, 16'h0, 16'h0);
    step(1'b1, 8'h10, 8'h00, 8'h02, 8'h80, 16'h0040, 16'h0, 16'h0, 16'h0);
    // R12 back-to-back pushes, then idle
    step(1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 16'hFFFF, 16'h0, 16'h0, 16'h0);
    step(1'b1, 8'hCD, 8'h00, 8'h00, 8'h00, 16'hFFFE, 16'h4321, 16'h0, 16'h0);
    step(1'b0, 8'hCD, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0, 16'h0, 16'h0);
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0, 16'h0, 16'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule